// File: doc/BRIEF.md
# Dual-Array Multi-Row Logic Memory

This block is a behavioural, synthesizable model of a memory bank that evaluates bitwise logic across many stored words in a single read. Each written word goes into two arrays. The first array holds the word as written. The second array holds its bitwise inverse. Both copies are updated in the same cycle.

The read side has no address. It takes a mask with one bit per row, and each set bit turns on that row's read wordline in both arrays. A bitline reads as one only if every selected cell stores a one. The true array therefore returns the AND of all selected words. The inverted array returns the AND of their complements, which is the NOR of the selected words. When only one row is selected, the two outputs are the word itself and its complement.

The write port is separate from the read port, so a store and a multi-operand read can share a cycle. Read results are registered, which gives one cycle of latency. The bank is meant to sit beside a scalar core as a wide bitwise operand engine.

Top module: `twin_array_logic_mem`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at row `wr_row` in the true array and stores its bitwise inverse in the complement array. Both take effect at the same clock edge.
- R2: Bit i of `rd_mask` selects row i and no other row. This holds for every position up to the top bit, ROWS-1.
- R3: With exactly one mask bit set, `rd_and` equals the stored word and `rd_nor` equals its bitwise inverse.
- R4: With two or more mask bits set, `rd_and` is the bitwise AND of the selected words and `rd_nor` is their bitwise NOR. As a consequence, `rd_and & rd_nor` is always zero.
- R5: All ROWS mask bits may be set at once, and the outputs are then the AND and NOR across every stored word.
- R6: An all-zero mask yields `rd_and` all ones and `rd_nor` all zeros.
- R7: The outputs change only at a rising clock edge. They reflect the mask and array contents present at that edge, so the read latency is one cycle.
- R8: When a write and a read that selects the same row share an edge, the read returns the row's previous contents. The new data is returned by the next read.
- R9: During reset, every row is cleared to zero (the complement array to all ones), `rd_and` goes to all ones and `rd_nor` to all zeros.
- R10: With `wr_en` low, `wr_row` and `wr_data` change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_row | input | AW = log2(ROWS) | Row written |
| wr_data | input | WIDTH | Word to store |
| rd_mask | input | ROWS | Row-select mask, bit i selects row i |
| rd_and | output | WIDTH | Registered AND of the selected words |
| rd_nor | output | WIDTH | Registered NOR of the selected words |

## Verification
The read port is driven with several kinds of mask:
- **Empty mask:** separates the idle outputs from a real evaluation.
- **One-hot masks:** walked across every row, including the top one. They show that each mask bit reaches only its own row and that the two arrays hold exact complements.
- **Sparse masks of two to four rows:** together with deliberately complementary word pairs, these tell AND apart from NOR and from plain OR.
- **The all-ones mask:** covers the widest wired combination.

Writes are also issued with the strobe low, and into the row being read in the same cycle. These show whether ignored writes leak into storage and whether a read sees the contents from before or after the write.

// File: rtl/tam_pkg.sv
package tam_pkg;

   // Which copy of the word an array keeps.
   typedef enum logic {
      POL_TRUE = 1'b0,
      POL_COMP = 1'b1
   } tam_pol_e;

   // Index width for a row count; at least one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tam_array.sv
module tam_array #(
   parameter int unsigned        ROWS  = 128,
   parameter int unsigned        WIDTH = 128,
   parameter tam_pkg::tam_pol_e  POL   = tam_pkg::POL_TRUE,
   localparam int unsigned       AW    = tam_pkg::idx_bits(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_row,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [ROWS-1:0]  sel,
   output logic [WIDTH-1:0] bitline
);

   localparam logic [WIDTH-1:0] CLEAR_WORD = (POL == tam_pkg::POL_COMP) ? '1 : '0;

   logic [WIDTH-1:0] cells [ROWS];
   logic [WIDTH-1:0] store_word;

   // The polarity picks what the write driver puts on the cells.
   generate
      if (POL == tam_pkg::POL_COMP) begin : g_inv_store
         assign store_word = ~wr_data;
      end else begin : g_true_store
         assign store_word = wr_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            cells[r] <= CLEAR_WORD;
         end
      end else if (wr_en) begin
         cells[wr_row] <= store_word;
      end
   end

   // Precharged bitline: any selected cell holding zero pulls it low.
   always_comb begin
      bitline = '1;
      for (int r = 0; r < ROWS; r++) begin
         if (sel[r]) begin
            bitline = bitline & cells[r];
         end
      end
   end

endmodule

// File: rtl/tam_sense.sv
module tam_sense #(
   parameter int unsigned WIDTH = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_any,
   input  logic [WIDTH-1:0] bl_true,
   input  logic [WIDTH-1:0] bl_comp,
   output logic [WIDTH-1:0] rd_and,
   output logic [WIDTH-1:0] rd_nor
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_and <= '1;
         rd_nor <= '0;
      end else begin
         rd_and <= bl_true;
         rd_nor <= sel_any ? bl_comp : '0;
      end
   end

endmodule

// File: rtl/twin_array_logic_mem.sv
module twin_array_logic_mem #(
   parameter int unsigned  ROWS  = 128,
   parameter int unsigned  WIDTH = 128,
   localparam int unsigned AW    = tam_pkg::idx_bits(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_row,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [ROWS-1:0]  rd_mask,
   output logic [WIDTH-1:0] rd_and,
   output logic [WIDTH-1:0] rd_nor
);

   generate
      if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
         $error("twin_array_logic_mem: ROWS must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("twin_array_logic_mem: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] bl [2];
   logic [WIDTH-1:0] bl_true;
   logic [WIDTH-1:0] bl_comp;

   for (genvar g = 0; g < 2; g++) begin : g_plane
      tam_array #(
         .ROWS  (ROWS),
         .WIDTH (WIDTH),
         .POL   ((g == 0) ? tam_pkg::POL_TRUE : tam_pkg::POL_COMP)
      ) u_array (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_row  (wr_row),
         .wr_data (wr_data),
         .sel     (rd_mask),
         .bitline (bl[g])
      );
   end

   assign bl_true = bl[0];
   assign bl_comp = bl[1];

   tam_sense #(
      .WIDTH (WIDTH)
   ) u_sense (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_any (|rd_mask),
      .bl_true (bl_true),
      .bl_comp (bl_comp),
      .rd_and  (rd_and),
      .rd_nor  (rd_nor)
   );

endmodule

// File: rtl/tam_checker.sv
module tam_checker #(
   parameter int unsigned ROWS  = 128,
   parameter int unsigned WIDTH = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic [ROWS-1:0]  rd_mask,
   input logic [WIDTH-1:0] bl_true,
   input logic [WIDTH-1:0] bl_comp,
   input logic [WIDTH-1:0] rd_and,
   input logic [WIDTH-1:0] rd_nor
);

   // R1: with one row selected, the two arrays present exact complements.
   p_twin_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(rd_mask) == 1) |-> (bl_true == ~bl_comp));

   // R3: a single-row read returns the word and its inverse.
   p_single_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(rd_mask) == 1) |=> (rd_and == ~rd_nor));

   // R4: no bit can be both the AND and the NOR of the same selection.
   p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_and & rd_nor) == '0));

   // R6: an empty mask leaves the precharged idle result.
   p_idle_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mask == '0) |=> (rd_and == '1 && rd_nor == '0));

endmodule

bind twin_array_logic_mem tam_checker #(
   .ROWS  (ROWS),
   .WIDTH (WIDTH)
) u_tam_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_mask (rd_mask),
   .bl_true (bl_true),
   .bl_comp (bl_comp),
   .rd_and  (rd_and),
   .rd_nor  (rd_nor)
);

// File: tb/tb_twin_array_logic_mem.sv
module tb_twin_array_logic_mem;

   localparam int unsigned ROWS       = 128;
   localparam int unsigned WIDTH      = 128;
   localparam int unsigned AW         = $clog2(ROWS);
   localparam int          CLK_PERIOD = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [AW-1:0]    wr_row = '0;
   logic [WIDTH-1:0] wr_data = '0;
   logic [ROWS-1:0]  rd_mask = '0;
   logic [WIDTH-1:0] rd_and;
   logic [WIDTH-1:0] rd_nor;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [WIDTH-1:0] model [ROWS];

   twin_array_logic_mem #(.ROWS(ROWS), .WIDTH(WIDTH)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_row  (wr_row),
      .wr_data (wr_data),
      .rd_mask (rd_mask),
      .rd_and  (rd_and),
      .rd_nor  (rd_nor)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [WIDTH-1:0] rand_word();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // Called at a falling edge; drives one cycle and checks the result at the next falling edge.
   task automatic step(input logic wen, input logic [AW-1:0] row,
                       input logic [WIDTH-1:0] data, input logic [ROWS-1:0] mask,
                       input string tag);
      logic [WIDTH-1:0] ea;
      logic [WIDTH-1:0] acc;
      logic [WIDTH-1:0] en;
      wr_en   = wen;
      wr_row  = row;
      wr_data = data;
      rd_mask = mask;
      ea  = '1;
      acc = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (mask[r]) begin
            ea  = ea & model[r];
            acc = acc | model[r];
         end
      end
      en = (mask != '0) ? ~acc : '0;
      if (wen) model[row] = data;
      @(posedge clk);
      @(negedge clk);
      check(tag, "and", rd_and, ea);
      check(tag, "nor", rd_nor, en);
   endtask

   function automatic logic [ROWS-1:0] one_row(input int r);
      logic [ROWS-1:0] m;
      m = '0;
      m[r] = 1'b1;
      return m;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [WIDTH-1:0] pat;
      for (int r = 0; r < ROWS; r++) model[r] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: idle outputs and cleared contents after reset
      check("R9", "and", rd_and, '1);
      check("R9", "nor", rd_nor, '0);
      step(1'b0, '0, '0, '1, "R9");

      // R1, R6: fill every row while the mask is empty
      for (int r = 0; r < ROWS; r++) begin
         step(1'b1, AW'(r), rand_word(), '0, "R6");
      end

      // R2, R3: walk a single bit across every row, top row included
      for (int r = 0; r < ROWS; r++) begin
         step(1'b0, '0, '0, one_row(r), "R3");
      end
      step(1'b1, AW'(ROWS - 1), {WIDTH/8{8'hA5}}, '0, "R1");
      step(1'b0, '0, '0, one_row(ROWS - 1), "R2");

      // R4: a word and its complement give zero for both AND and NOR
      pat = rand_word();
      step(1'b1, AW'(1), pat, '0, "R1");
      step(1'b1, AW'(2), ~pat, '0, "R1");
      step(1'b0, '0, '0, one_row(1) | one_row(2), "R4");
      step(1'b1, AW'(3), pat | {WIDTH/2{2'b01}}, '0, "R1");
      step(1'b0, '0, '0, one_row(1) | one_row(3), "R4");

      // R5: every row at once
      step(1'b0, '0, '0, '1, "R5");

      // R10: write strobe low leaves the row untouched
      step(1'b0, AW'(7), ~model[7], '0, "R10");
      step(1'b0, '0, '0, one_row(7), "R10");

      // R8: write and read of the same row in one cycle
      step(1'b1, AW'(5), rand_word(), one_row(5), "R8");
      step(1'b0, '0, '0, one_row(5), "R8");

      // R7: output holds until the edge, then shows the new selection
      step(1'b0, '0, '0, one_row(3), "R7");
      rd_mask = one_row(4);
      #(CLK_PERIOD / 4);
      check("R7", "and", rd_and, model[3]);
      @(posedge clk);
      @(negedge clk);
      check("R7", "and", rd_and, model[4]);

      // R4, R8: sparse multi-row masks mixed with writes
      for (int i = 0; i < 300; i++) begin
         logic [ROWS-1:0] m;
         int k;
         m = '0;
         k = 2 + int'($urandom_range(2));
         for (int j = 0; j < k; j++) m[$urandom_range(ROWS - 1)] = 1'b1;
         step(1'($urandom_range(1)), AW'($urandom_range(ROWS - 1)), rand_word(), m, "R4");
      end

      // R6: empty mask again after activity
      step(1'b0, '0, '0, '0, "R6");

      finish_run();
   end

endmodule